// File: doc/BRIEF.md
# Power-Management Bus Write Receiver

This block is the receive side of a slave on a two-wire power-management serial bus. It oversamples the clock line and the data line with the fast system clock, finds the framing conditions, and takes in write packets addressed to it. Each packet holds an address byte, a command byte, some data bytes and, when the packet error code option is on, a trailing CRC byte. The receiver acknowledges each byte it accepts by pulling the data line low. It only ever pulls low or lets go, because the bus is wired-AND.

The whole packet is held inside the block. Nothing reaches the register-file side until the stop condition arrives. At that point the packet is checked, and it is then either released as a single command strobe with its code, data bytes and length, or dropped with a one-cycle error pulse. The block does not need a separate "execute" step: a good command is handed on as soon as the stop is seen. A write-protect input blocks every commit. Command codes 0xFE and 0xFF are treated as prefixes that extend the command into the first data byte.

Top module: `pwr_cmd_rx`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Data bits are taken on SCL rising edges, most significant bit first.
- R2: The first byte after a start is accepted only when bits 7:1 equal `devAddr` and bit 0 (direction) is 0. Any other first byte gets no acknowledge, and the rest of that transfer causes neither a strobe nor an error pulse.
- R3: For each accepted byte, `sdaPullLow` goes high after the SCL falling edge that ends bit 8 and goes low after the next SCL falling edge. It rises only while SCL is low.
- R4: When a stop ends an accepted, valid packet, `cmdValid` pulses for exactly one cycle. In that cycle `cmdCode` holds the command byte, `cmdLen` holds the number of data bytes, and data byte k sits in `cmdData[8k+7:8k]`, with lanes at or above `cmdLen` reading zero. No strobe is issued before the stop, and `cmdValid` and `errPulse` are never high together.
- R5: With `pecEnable` high, the last byte after the command is a CRC-8 check byte. The CRC uses polynomial 0x07 and starts from 0, and it covers the address byte, the command byte and all data bytes. A matching check byte is not counted in `cmdLen`. A mismatch gives `errPulse` and no strobe.
- R6: With `pecEnable` low, every byte after the command is data and no check is made.
- R7: At most MAX_DATA data bytes are accepted, plus the check byte when `pecEnable` is high. Any byte beyond that is not acknowledged, and the packet ends in `errPulse`.
- R8: A start that arrives after the block has accepted its address aborts the packet with `errPulse`. The next address byte is then processed as a new packet.
- R9: If `wrProtect` is high when the stop arrives, the packet gives `errPulse` and no strobe.
- R10: Command codes 0xFE and 0xFF set `cmdExt` on the strobe. Such a packet with zero data bytes is rejected with `errPulse`.
- R11: An accepted address followed directly by a stop, with no command byte, gives `errPulse`.
- R12: During reset, `cmdValid`, `errPulse` and `sdaPullLow` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaPullLow | output | 1 | 1 pulls SDA low, 0 releases it |
| devAddr | input | 7 | Own 7-bit bus address |
| pecEnable | input | 1 | 1: the packet ends with a CRC-8 check byte |
| wrProtect | input | 1 | 1: block every commit |
| cmdValid | output | 1 | One-cycle command strobe |
| cmdCode | output | 8 | Command byte |
| cmdExt | output | 1 | Command is an extension prefix |
| cmdLen | output | $clog2(MAX_DATA+1) | Number of data bytes |
| cmdData | output | 8*MAX_DATA | Data bytes, byte 0 in the low lane |
| errPulse | output | 1 | One-cycle reject pulse |

## Verification
The bench builds the block with MAX_DATA set to 3 and two synchronizer stages. This size lets a few short packets reach the interesting points. A command with three data bytes fills the buffer exactly, both with and without a check byte. A fourth data byte reaches the point where the acknowledge is withheld. The same small depth also shows the zero fill of unused data lanes after short commands. A repeated start, a write with only an address, a wrong address and a read-direction address are each driven through the wired-AND line model.

// File: rtl/pwr_cmd_pkg.sv
package pwr_cmd_pkg;

  localparam logic [7:0] EXT_PREFIX_A = 8'hFE;
  localparam logic [7:0] EXT_PREFIX_B = 8'hFF;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // new transfer: drop packet state
    logic sample;   // shift one bit in
    logic capture;  // byte complete and belongs to this device
    logic commit;   // stop on a good packet
    logic reject;   // packet dropped with error
  } dpCtl_t;

  typedef enum logic [1:0] {PH_IDLE, PH_BITS, PH_ACKWAIT, PH_ACK} phase_t;

  // CRC-8, polynomial 0x07, one byte at a time
  function automatic logic [7:0] crc8Step(input logic [7:0] crcIn, input logic [7:0] dataIn);
    logic [7:0] c;
    c = crcIn ^ dataIn;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/pwr_cmd_ctrl.sv
module pwr_cmd_ctrl
  import pwr_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic [6:0]   devAddr,
  input  logic [7:0]   newByte,
  input  logic         byteFits,
  input  logic         pktGood,
  output dpCtl_t       ctl,
  output logic         sdaBit,
  output logic         sdaPullLow
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclS, sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS   = sclPipe[SYNC_STAGES-1];
  assign sdaS   = sdaPipe[SYNC_STAGES-1];
  assign sdaBit = sdaS;

  logic sclRise, sclFall, startEv, stopEv;
  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;

  phase_t     phase;
  logic [2:0] bitCnt;
  logic       ownPkt;
  logic       ackGo;
  logic       lastBit, addrHit;

  assign addrHit = (newByte[7:1] == devAddr) && !newByte[0];

  always_comb begin
    ctl         = '0;
    ctl.sample  = (phase == PH_BITS) && sclRise;
    lastBit     = ctl.sample && (bitCnt == 3'd7);
    ctl.capture = lastBit && (ownPkt || addrHit);
    ctl.clear   = startEv;
    ctl.commit  = stopEv && ownPkt && pktGood;
    ctl.reject  = (stopEv && ownPkt && !pktGood) || (startEv && ownPkt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      bitCnt     <= 3'd0;
      ownPkt     <= 1'b0;
      ackGo      <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (startEv) begin
      phase      <= PH_BITS;
      bitCnt     <= 3'd0;
      ownPkt     <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (stopEv) begin
      phase      <= PH_IDLE;
      bitCnt     <= 3'd0;
      ownPkt     <= 1'b0;
      sdaPullLow <= 1'b0;
    end else begin
      unique case (phase)
        PH_BITS: if (sclRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            phase <= PH_ACKWAIT;
            ackGo <= ownPkt ? byteFits : addrHit;
            if (!ownPkt) ownPkt <= addrHit;
          end
        end
        PH_ACKWAIT: if (sclFall) begin
          sdaPullLow <= ackGo;
          phase      <= PH_ACK;
        end
        PH_ACK: if (sclFall) begin
          sdaPullLow <= 1'b0;
          bitCnt     <= 3'd0;
          phase      <= ownPkt ? PH_BITS : PH_IDLE;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pwr_cmd_dp.sv
module pwr_cmd_dp
  import pwr_cmd_pkg::*;
#(
  parameter int MAX_DATA = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCtl_t                        ctl,
  input  logic                          sdaBit,
  input  logic                          pecEnable,
  input  logic                          wrProtect,
  output logic [7:0]                    newByte,
  output logic                          byteFits,
  output logic                          pktGood,
  output logic                          cmdValid,
  output logic [7:0]                    cmdCode,
  output logic                          cmdExt,
  output logic [$clog2(MAX_DATA+1)-1:0] cmdLen,
  output logic [8*MAX_DATA-1:0]         cmdData,
  output logic                          errPulse
);

  localparam int BUFN = MAX_DATA + 1;
  localparam int CNTW = $clog2(MAX_DATA + 4);
  localparam int LENW = $clog2(MAX_DATA + 1);
  localparam logic [CNTW-1:0] BASE_LIM = CNTW'(MAX_DATA + 2);

  logic [7:0]      shiftReg, crcReg, cmdReg;
  logic [CNTW-1:0] byteCnt, limit, needCnt, dataCnt;
  logic            ovf, extCode, enough;
  logic [7:0]      bufMem [BUFN];

  assign newByte  = {shiftReg[6:0], sdaBit};
  assign limit    = BASE_LIM + CNTW'(pecEnable);
  assign byteFits = byteCnt < limit;
  assign needCnt  = CNTW'(2) + CNTW'(pecEnable);
  assign enough   = byteCnt >= needCnt;
  assign dataCnt  = byteCnt - needCnt;
  assign extCode  = (cmdReg == EXT_PREFIX_A) || (cmdReg == EXT_PREFIX_B);
  assign pktGood  = enough && !ovf && !wrProtect
                    && (!pecEnable || crcReg == 8'h00)
                    && !(extCode && dataCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      crcReg   <= '0;
      cmdReg   <= '0;
      byteCnt  <= '0;
      ovf      <= 1'b0;
    end else begin
      if (ctl.sample) shiftReg <= newByte;
      if (ctl.clear) begin
        crcReg  <= '0;
        byteCnt <= '0;
        ovf     <= 1'b0;
      end else if (ctl.capture) begin
        if (byteFits) begin
          crcReg  <= crc8Step(crcReg, newByte);
          byteCnt <= byteCnt + CNTW'(1);
          if (byteCnt == CNTW'(1)) cmdReg <= newByte;
        end else begin
          ovf <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < BUFN; g++) begin : g_buf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bufMem[g] <= '0;
      else if (ctl.capture && byteFits && byteCnt == CNTW'(g + 2)) bufMem[g] <= newByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      errPulse <= 1'b0;
      cmdCode  <= '0;
      cmdExt   <= 1'b0;
      cmdLen   <= '0;
    end else begin
      cmdValid <= ctl.commit;
      errPulse <= ctl.reject;
      if (ctl.commit) begin
        cmdCode <= cmdReg;
        cmdExt  <= extCode;
        cmdLen  <= LENW'(dataCnt);
      end
    end
  end

  for (genvar k = 0; k < MAX_DATA; k++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cmdData[8*k +: 8] <= '0;
      else if (ctl.commit) cmdData[8*k +: 8] <= (CNTW'(k) < dataCnt) ? bufMem[k] : 8'h00;
    end
  end

endmodule

// File: rtl/pwr_cmd_rx.sv
module pwr_cmd_rx
  import pwr_cmd_pkg::*;
#(
  parameter int MAX_DATA    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sclIn,
  input  logic                          sdaIn,
  output logic                          sdaPullLow,
  input  logic [6:0]                    devAddr,
  input  logic                          pecEnable,
  input  logic                          wrProtect,
  output logic                          cmdValid,
  output logic [7:0]                    cmdCode,
  output logic                          cmdExt,
  output logic [$clog2(MAX_DATA+1)-1:0] cmdLen,
  output logic [8*MAX_DATA-1:0]         cmdData,
  output logic                          errPulse
);

  dpCtl_t     ctlBus;
  logic       sdaBit, byteFits, pktGood;
  logic [7:0] newByte;

  pwr_cmd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .devAddr(devAddr),
    .newByte(newByte), .byteFits(byteFits), .pktGood(pktGood),
    .ctl(ctlBus), .sdaBit(sdaBit), .sdaPullLow(sdaPullLow)
  );

  pwr_cmd_dp #(.MAX_DATA(MAX_DATA)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .sdaBit(sdaBit),
    .pecEnable(pecEnable), .wrProtect(wrProtect),
    .newByte(newByte), .byteFits(byteFits), .pktGood(pktGood),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdExt(cmdExt),
    .cmdLen(cmdLen), .cmdData(cmdData), .errPulse(errPulse)
  );

endmodule

// File: rtl/pwr_cmd_chk.sv
module pwr_cmd_chk #(
  parameter int MAX_DATA = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          sclIn,
  input logic                          sdaPullLow,
  input logic                          wrProtect,
  input logic                          cmdValid,
  input logic [7:0]                    cmdCode,
  input logic [$clog2(MAX_DATA+1)-1:0] cmdLen,
  input logic                          errPulse
);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  a_r4_no_both: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && errPulse));

  a_r9_wp_blocks: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !$past(wrProtect));

  a_r7_len_bound: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (int'(cmdLen) <= MAX_DATA));

  a_r10_ext_has_data: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode >= 8'hFE) |-> (cmdLen != '0));

  a_r3_ack_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn);

endmodule

bind pwr_cmd_rx pwr_cmd_chk #(.MAX_DATA(MAX_DATA)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .wrProtect(wrProtect), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .cmdLen(cmdLen), .errPulse(errPulse)
);

// File: tb/sim_pwr_cmd_rx.sv
module sim_pwr_cmd_rx;

  localparam int MAXD = 3;
  localparam int LENW = $clog2(MAXD + 1);
  localparam int Q    = 6;
  localparam logic [6:0] MY_ADDR = 7'h2C;

  typedef struct packed {
    logic        pec;
    logic        wp;
    logic        badPec;
    logic [2:0]  n;       // command byte plus data bytes
    logic [39:0] bytes;   // command in the top byte
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 3'd1, 40'h01_00_00_00_00},
    '{1'b0, 1'b0, 1'b0, 3'd3, 40'h21_34_12_00_00},
    '{1'b0, 1'b0, 1'b0, 3'd4, 40'h40_AA_55_C3_00},
    '{1'b0, 1'b0, 1'b0, 3'd5, 40'h41_01_02_03_04},
    '{1'b1, 1'b0, 1'b0, 3'd3, 40'h22_5A_A5_00_00},
    '{1'b1, 1'b0, 1'b1, 3'd2, 40'h23_77_00_00_00},
    '{1'b0, 1'b1, 1'b0, 3'd2, 40'h24_66_00_00_00},
    '{1'b0, 1'b0, 1'b0, 3'd1, 40'hFE_00_00_00_00},
    '{1'b0, 1'b0, 1'b0, 3'd2, 40'hFF_10_00_00_00},
    '{1'b1, 1'b0, 1'b0, 3'd4, 40'h79_01_02_03_00},
    '{1'b1, 1'b0, 1'b0, 3'd1, 40'h03_00_00_00_00}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic pecEn = 1'b0, wp = 1'b0;
  logic sdaLine, sdaPullLow, cmdValid, cmdExt, errPulse;
  logic [7:0] cmdCode;
  logic [LENW-1:0] cmdLen;
  logic [8*MAXD-1:0] cmdData;

  int total = 0, bad = 0, strobeCnt = 0, errCnt = 0;
  logic done = 1'b0;
  logic [7:0] capCode;
  logic capExt;
  logic [LENW-1:0] capLen;
  logic [8*MAXD-1:0] capData;

  assign sdaLine = sdaM & ~sdaPullLow;

  always #4 clk = ~clk;

  pwr_cmd_rx #(.MAX_DATA(MAXD), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaPullLow(sdaPullLow),
    .devAddr(MY_ADDR), .pecEnable(pecEn), .wrProtect(wp),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdExt(cmdExt),
    .cmdLen(cmdLen), .cmdData(cmdData), .errPulse(errPulse)
  );

  always @(posedge clk) begin
    if (cmdValid) begin
      strobeCnt <= strobeCnt + 1;
      capCode   <= cmdCode;
      capExt    <= cmdExt;
      capLen    <= cmdLen;
      capData   <= cmdData;
    end
    if (errPulse) errCnt <= errCnt + 1;
  end

  function automatic logic [7:0] benchCrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ();
      sclM = 1'b1; waitQ(); waitQ();
      sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    acked = !sdaLine;
    waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic runVec(input vec_t v, input int idx);
    logic [7:0] b [6];
    logic [7:0] c;
    logic ack, good;
    int nb, dl, s0, e0;
    logic [8*MAXD-1:0] expData;
    pecEn = v.pec;
    wp    = v.wp;
    for (int j = 0; j < 5; j++) b[j] = v.bytes[39-8*j -: 8];
    b[5] = 8'h00;
    nb = int'(v.n);
    dl = nb - 1;
    c = benchCrc(8'h00, {MY_ADDR, 1'b0});
    for (int j = 0; j < nb; j++) c = benchCrc(c, b[j]);
    if (v.pec) begin
      b[nb] = v.badPec ? (c ^ 8'h5A) : c;
      nb++;
    end
    good = !v.wp && !v.badPec && dl <= MAXD && !(b[0] >= 8'hFE && dl == 0);
    expData = '0;
    for (int k = 0; k < MAXD; k++) if (k < dl) expData[8*k +: 8] = b[k+1];
    s0 = strobeCnt;
    e0 = errCnt;
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    check($sformatf("R2 address ack vec%0d", idx), ack, 1);
    for (int j = 0; j < nb; j++) begin
      sendByte(b[j], ack);
      check($sformatf("R3 R7 byte ack vec%0d byte%0d", idx, j), ack, (j < 1 + MAXD + int'(v.pec)));
    end
    settle();
    check($sformatf("R4 no strobe before stop vec%0d", idx), strobeCnt - s0, 0);
    busStop();
    settle();
    check($sformatf("R4 R5 R6 R7 R9 R10 strobe vec%0d", idx), strobeCnt - s0, good);
    check($sformatf("R5 R7 R9 R10 error vec%0d", idx), errCnt - e0, !good);
    if (good) begin
      check($sformatf("R1 code vec%0d", idx), capCode, b[0]);
      check($sformatf("R4 length vec%0d", idx), capLen, dl);
      check($sformatf("R4 data lanes vec%0d", idx), capData, expData);
      check($sformatf("R10 ext flag vec%0d", idx), capExt, b[0] >= 8'hFE);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic ack;
    int s0, e0;
    repeat (5) @(negedge clk);
    check("R12 cmdValid in reset", cmdValid, 0);
    check("R12 errPulse in reset", errPulse, 0);
    check("R12 sdaPullLow in reset", sdaPullLow, 0);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // wrong address: no ack, nothing reported
    pecEn = 1'b0; wp = 1'b0;
    s0 = strobeCnt; e0 = errCnt;
    busStart();
    sendByte({7'h2D, 1'b0}, ack);
    check("R2 foreign address nack", ack, 0);
    sendByte(8'h01, ack);
    check("R2 foreign command nack", ack, 0);
    busStop(); settle();
    check("R2 foreign strobe", strobeCnt - s0, 0);
    check("R2 foreign error", errCnt - e0, 0);

    // read direction: no ack, nothing reported
    busStart();
    sendByte({MY_ADDR, 1'b1}, ack);
    check("R2 read direction nack", ack, 0);
    busStop(); settle();
    check("R2 read strobe", strobeCnt - s0, 0);
    check("R2 read error", errCnt - e0, 0);

    // repeated start aborts, next packet still works
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    sendByte(8'h11, ack);
    sendByte(8'h22, ack);
    busStart(); settle();
    check("R8 abort error", errCnt - e0, 1);
    check("R8 abort no strobe", strobeCnt - s0, 0);
    sendByte({MY_ADDR, 1'b0}, ack);
    check("R8 readdress ack", ack, 1);
    sendByte(8'h33, ack);
    busStop(); settle();
    check("R8 follow-up strobe", strobeCnt - s0, 1);
    check("R8 follow-up code", capCode, 8'h33);
    check("R4 follow-up zero lanes", capData, 0);

    // address then stop
    s0 = strobeCnt; e0 = errCnt;
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    busStop(); settle();
    check("R11 address-only error", errCnt - e0, 1);
    check("R11 address-only strobe", strobeCnt - s0, 0);
    check("R3 line released idle", sdaPullLow, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule